// File: doc/BRIEF.md
# I2C Message Sequencer

This block drives a single I2C master transfer from its first command to its end without software stepping each byte. It sits next to a master core that does the bus-level bit timing. That core reports each bus event as an 8-bit status code, and it takes commands such as start, address, data, continue and stop. The user gives the sequencer a target address, three flags (10-bit addressing, read direction, skip the start and address phase) and a byte count, and then pulses `start_i`. For each status code, the sequencer chooses the next command and presents it to the core. Bytes to send come from the head of a transmit buffer, which the sequencer pops. Received bytes are pushed into a receive buffer.

The acknowledge bit is decided before each read byte arrives, so the last byte of a read is not acknowledged. A message can end in four ways: it completes, the target does not answer, the core reports an unexpected code, or a two-stage watchdog fires. In every case the sequencer pulses `done_o` and reports a 2-bit result code.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset the block is idle. `busy_o`, `act_valid_o`, `done_o`, `core_rst_o`, `tx_pop_o`, `rx_push_o` and `ien_o` are all 0.
- R2: A `start_i` pulse while idle latches the message. The action codes on `act_o` are 1 start, 2 first address, 3 second address, 4 data, 5 receive, 6 continue and 7 stop. Without the skip flag, the next cycle shows action 1 with `ack_o` and `ien_o` at 1. A `start_i` pulse while busy changes nothing.
- R3: Status 0x08 or 0x10 gives action 2. Its `wdata_o` is {addr[6:0], rd} for 7-bit addressing, or 0xF0 | addr[9:8]<<1 | rd for 10-bit addressing. Status 0x18 or 0x40 with the 10-bit flag set gives action 3 with `wdata_o` = addr[7:0].
- R4: On 0x18 (7-bit), 0xD0 or 0x28, the block sends action 4 while bytes remain. That action carries the buffer head and pulses `tx_pop_o`. When no bytes remain, it sends action 7, pulses `done_o` and sets result 0 (ok).
- R5: On 0x40 (7-bit) or 0xE0, the block stops with result 0 if the length is zero. Otherwise it sends action 6. On 0x50 it sends action 5 and pushes `core_rdata_i`. On 0x58 it pushes the byte, sends action 7 and pulses `done_o` with result 0. `ack_o` falls to 0 once a single byte remains, so the last byte is not acknowledged.
- R6: Status 0x20, 0x30 or 0x48 gives action 7 with `done_o` and result 1 (no device).
- R7: Any status code not listed in R3 to R6 pulses `core_rst_o` and gives action 7 with `done_o` and result 2 (I/O error).
- R8: A status pulse while idle gives only action 7. There is no `done_o` and no buffer access.
- R9: Every action 7 is presented with `ien_o` at 0.
- R10: With the skip flag, a read starts with action 6, and `ack_o` is already 0 when the length is 1. A write starts with action 4, which pops the first byte.
- R11: An `abort_i` pulse while busy is held until the message ends. On the write path, the next write acknowledge code then gives action 7 once at least one byte has been sent. On the read path, the next action drives `ack_o` to 0.
- R12: The block counts busy cycles that carry no status pulse. When the count reaches `tmo_i + 1`, the block raises the internal abort and restarts the count. A second such window pulses `core_rst_o` and `done_o` with result 3 and returns to idle, with no stop action. A normal stop that happens after the first window reports result 3.
- R13: Every action, pop, push, done and result appears in the cycle after the edge that sampled `start_i`, the status pulse, or the watchdog expiry that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a message (ignored while busy) |
| addr_i | input | 10 | Target address |
| ten_i | input | 1 | 10-bit addressing |
| rd_i | input | 1 | Read direction |
| nostart_i | input | 1 | Skip the start and address phase |
| len_i | input | LEN_W | Byte count |
| abort_i | input | 1 | Abort request pulse |
| tmo_i | input | TMO_W | Watchdog window in idle-status cycles |
| stat_valid_i | input | 1 | Core reports a status this cycle |
| stat_i | input | 8 | Core status code |
| core_rdata_i | input | 8 | Byte received by the core |
| tx_data_i | input | 8 | Head of the transmit buffer |
| act_valid_o | output | 1 | Command valid for one cycle |
| act_o | output | 3 | Command code (see R2) |
| wdata_o | output | 8 | Address or data byte for the core |
| ack_o | output | 1 | Acknowledge bit for the next received byte |
| ien_o | output | 1 | Core interrupt enable |
| core_rst_o | output | 1 | Soft reset pulse to the core |
| tx_pop_o | output | 1 | Transmit buffer head consumed |
| rx_push_o | output | 1 | Push `rx_data_o` into the receive buffer |
| rx_data_o | output | 8 | Received byte |
| done_o | output | 1 | Message finished |
| result_o | output | 2 | 0 ok, 1 no device, 2 I/O error, 3 timeout |
| busy_o | output | 1 | Message in progress |

## Verification
Each command, pop, push and completion is registered exactly one edge after the status pulse or start request that caused it. The bench therefore raises a stimulus on a falling edge, lets one rising edge pass, and samples on the next falling edge. The watchdog result falls due 2·`tmo_i`+2 edges after the start edge when no status arrives, and the bench counts falling edges until `done_o` and compares that count. The transmit buffer model advances on the falling edge after a pop, so each data byte is checked against an index that the bench keeps itself.

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq #(
  parameter int LEN_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [9:0]       addr_i,
  input  logic             ten_i,
  input  logic             rd_i,
  input  logic             nostart_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             abort_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             stat_valid_i,
  input  logic [7:0]       stat_i,
  input  logic [7:0]       core_rdata_i,
  input  logic [7:0]       tx_data_i,
  output logic             act_valid_o,
  output logic [2:0]       act_o,
  output logic [7:0]       wdata_o,
  output logic             ack_o,
  output logic             ien_o,
  output logic             core_rst_o,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  output logic             done_o,
  output logic [1:0]       result_o,
  output logic             busy_o
);

  localparam logic [2:0] A_START = 3'd1, A_ADDR1 = 3'd2, A_ADDR2 = 3'd3,
                         A_DATA  = 3'd4, A_RECV  = 3'd5, A_CONT  = 3'd6, A_STOP = 3'd7;
  localparam logic [1:0] RES_OK = 2'd0, RES_NODEV = 2'd1, RES_IOERR = 2'd2, RES_TMO = 2'd3;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

  typedef enum logic [2:0] {S_IDLE, S_WSTART, S_WA1, S_WA2, S_WACK, S_WDATA} st_t;

  st_t              st;
  logic [7:0]       a1_r, a2_r;
  logic             ten_r, sent_r, abrt_r, tmo_r, ack_r, ien_r;
  logic [LEN_W-1:0] left_r;
  logic [TMO_W-1:0] cnt_r;
  logic [1:0]       ok_res;

  assign busy_o = (st != S_IDLE);
  assign ack_o  = ack_r;
  assign ien_o  = ien_r;
  assign ok_res = tmo_r ? RES_TMO : RES_OK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      a1_r <= '0; a2_r <= '0; ten_r <= 1'b0; sent_r <= 1'b0;
      abrt_r <= 1'b0; tmo_r <= 1'b0; ack_r <= 1'b0; ien_r <= 1'b0;
      left_r <= '0; cnt_r <= '0;
      act_valid_o <= 1'b0; act_o <= '0; wdata_o <= '0;
      core_rst_o <= 1'b0; tx_pop_o <= 1'b0; rx_push_o <= 1'b0; rx_data_o <= '0;
      done_o <= 1'b0; result_o <= RES_OK;
    end else begin
      act_valid_o <= 1'b0;
      tx_pop_o    <= 1'b0;
      rx_push_o   <= 1'b0;
      done_o      <= 1'b0;
      core_rst_o  <= 1'b0;
      if (busy_o && abort_i) abrt_r <= 1'b1;

      if (stat_valid_i) begin
        act_valid_o <= 1'b1;
        if (st == S_IDLE) begin
          act_o <= A_STOP;
          ien_r <= 1'b0;
        end else begin
          case (stat_i)
            8'h08, 8'h10: begin
              act_o <= A_ADDR1; wdata_o <= a1_r; st <= S_WA1;
            end
            8'h18, 8'hD0, 8'h28: begin
              if (stat_i == 8'h18 && ten_r) begin
                act_o <= A_ADDR2; wdata_o <= a2_r; st <= S_WA2;
              end else if (left_r == '0 || (abrt_r && sent_r)) begin
                act_o <= A_STOP; ien_r <= 1'b0; done_o <= 1'b1;
                result_o <= ok_res; st <= S_IDLE;
              end else begin
                act_o <= A_DATA; wdata_o <= tx_data_i; tx_pop_o <= 1'b1;
                left_r <= left_r - ONE; sent_r <= 1'b1; st <= S_WACK;
              end
            end
            8'h40, 8'hE0: begin
              if (stat_i == 8'h40 && ten_r) begin
                act_o <= A_ADDR2; wdata_o <= a2_r; st <= S_WA2;
              end else if (left_r == '0) begin
                act_o <= A_STOP; ien_r <= 1'b0; done_o <= 1'b1;
                result_o <= ok_res; st <= S_IDLE;
              end else begin
                act_o <= A_CONT; st <= S_WDATA;
                if (left_r == ONE || abrt_r) ack_r <= 1'b0;
              end
            end
            8'h50: begin
              act_o <= A_RECV; rx_push_o <= 1'b1; rx_data_o <= core_rdata_i;
              left_r <= left_r - ONE; st <= S_WDATA;
              if (left_r == TWO || abrt_r) ack_r <= 1'b0;
            end
            8'h58: begin
              rx_push_o <= 1'b1; rx_data_o <= core_rdata_i;
              act_o <= A_STOP; ien_r <= 1'b0; done_o <= 1'b1;
              result_o <= ok_res; st <= S_IDLE;
            end
            8'h20, 8'h30, 8'h48: begin
              act_o <= A_STOP; ien_r <= 1'b0; done_o <= 1'b1;
              result_o <= RES_NODEV; st <= S_IDLE;
            end
            default: begin
              core_rst_o <= 1'b1;
              act_o <= A_STOP; ien_r <= 1'b0; done_o <= 1'b1;
              result_o <= RES_IOERR; st <= S_IDLE;
            end
          endcase
        end
      end else if (busy_o) begin
        if (cnt_r == tmo_i) begin
          cnt_r <= '0;
          if (!tmo_r) begin
            tmo_r  <= 1'b1;
            abrt_r <= 1'b1;
          end else begin
            core_rst_o <= 1'b1; done_o <= 1'b1; result_o <= RES_TMO;
            ien_r <= 1'b0; st <= S_IDLE;
          end
        end else begin
          cnt_r <= cnt_r + 1'b1;
        end
      end else if (start_i) begin
        ten_r  <= ten_i;
        a1_r   <= ten_i ? {5'b11110, addr_i[9:8], rd_i} : {addr_i[6:0], rd_i};
        a2_r   <= addr_i[7:0];
        ack_r  <= 1'b1; ien_r <= 1'b1;
        abrt_r <= 1'b0; tmo_r <= 1'b0; cnt_r <= '0; sent_r <= 1'b0;
        act_valid_o <= 1'b1;
        if (nostart_i && rd_i) begin
          act_o <= A_CONT; left_r <= len_i; st <= S_WDATA;
          if (len_i == ONE) ack_r <= 1'b0;
        end else if (nostart_i) begin
          act_o <= A_DATA; wdata_o <= tx_data_i; tx_pop_o <= 1'b1;
          left_r <= len_i - ONE; sent_r <= 1'b1; st <= S_WACK;
        end else begin
          act_o <= A_START; left_r <= len_i; st <= S_WSTART;
        end
      end
    end
  end

  assert_stop_drops_ien_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid_o && act_o == A_STOP) |-> !ien_o);

  assert_pop_with_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_o |-> (act_valid_o && act_o == A_DATA));

  assert_push_with_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_o |-> (act_valid_o && (act_o == A_RECV || act_o == A_STOP)));

  assert_done_leaves_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_core_reset_ends_msg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> (done_o && !busy_o));

  assert_status_answered_R13: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid_i |=> act_valid_o);

endmodule

// File: tb/i2c_msg_seq_bench.sv
module i2c_msg_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 0, ten_i = 0, rd_i = 0, nostart_i = 0, abort_i = 0;
  logic [9:0]  addr_i = '0;
  logic [7:0]  len_i = '0;
  logic [15:0] tmo_i = 16'hFFFF;
  logic        stat_valid_i = 0;
  logic [7:0]  stat_i = '0, core_rdata_i = '0, tx_data_i;
  logic        act_valid_o, ack_o, ien_o, core_rst_o, tx_pop_o, rx_push_o, done_o, busy_o;
  logic [2:0]  act_o;
  logic [7:0]  wdata_o, rx_data_o;
  logic [1:0]  result_o;

  int tests = 0, fails = 0;
  logic [7:0] tx_idx = '0;
  int eidx = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] fbyte(input int i);
    return 8'((i * 37) + 5);
  endfunction

  function automatic logic [7:0] exp_a1(input logic [9:0] a, input logic ten, input logic rd);
    return ten ? (8'hF0 | {5'b0, a[9:8], 1'b0} | {7'b0, rd}) : {a[6:0], rd};
  endfunction

  assign tx_data_i = fbyte(int'(tx_idx));
  always @(negedge clk) if (tx_pop_o) tx_idx <= tx_idx + 8'd1;

  i2c_msg_seq u_i2c_msg_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .ten_i(ten_i),
    .rd_i(rd_i), .nostart_i(nostart_i), .len_i(len_i), .abort_i(abort_i), .tmo_i(tmo_i),
    .stat_valid_i(stat_valid_i), .stat_i(stat_i), .core_rdata_i(core_rdata_i),
    .tx_data_i(tx_data_i), .act_valid_o(act_valid_o), .act_o(act_o), .wdata_o(wdata_o),
    .ack_o(ack_o), .ien_o(ien_o), .core_rst_o(core_rst_o), .tx_pop_o(tx_pop_o),
    .rx_push_o(rx_push_o), .rx_data_o(rx_data_o), .done_o(done_o), .result_o(result_o),
    .busy_o(busy_o));

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go(input logic [9:0] a, input logic ten, input logic rd,
                    input logic ns, input logic [7:0] len);
    addr_i = a; ten_i = ten; rd_i = rd; nostart_i = ns; len_i = len; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic stat(input logic [7:0] s, input logic [7:0] rd);
    stat_valid_i = 1'b1; stat_i = s; core_rdata_i = rd;
    @(negedge clk);
    stat_valid_i = 1'b0;
  endtask

  task automatic pulse_abort();
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
  endtask

  task automatic expect_act(input string req, input logic [2:0] code);
    check(req, {act_valid_o, act_o}, {1'b1, code});
  endtask

  task automatic expect_stop(input string req, input logic [1:0] res);
    check(req, {act_valid_o, act_o, done_o, result_o, ien_o, busy_o},
               {1'b1, 3'd7, 1'b1, res, 1'b0, 1'b0});
  endtask

  task automatic expect_data(input string req);
    check(req, {act_valid_o, act_o, tx_pop_o, wdata_o}, {1'b1, 3'd4, 1'b1, fbyte(eidx)});
    eidx++;
  endtask

  task automatic run_msg(input logic [9:0] a, input logic ten, input logic rd, input logic [7:0] len);
    logic [7:0] ac, b;
    go(a, ten, rd, 1'b0, len);
    check("R2 start", {act_valid_o, act_o, ack_o, ien_o, busy_o}, {1'b1, 3'd1, 1'b1, 1'b1, 1'b1});
    stat(8'h08, 8'h00);
    check("R3 addr1", {act_valid_o, act_o, wdata_o}, {1'b1, 3'd2, exp_a1(a, ten, rd)});
    if (ten) begin
      stat(rd ? 8'h40 : 8'h18, 8'h00);
      check("R3 addr2", {act_valid_o, act_o, wdata_o}, {1'b1, 3'd3, a[7:0]});
      ac = rd ? 8'hE0 : 8'hD0;
    end else begin
      ac = rd ? 8'h40 : 8'h18;
    end
    if (!rd) begin
      stat(ac, 8'h00);
      for (int i = 0; i < int'(len); i++) begin
        expect_data("R4 data");
        stat(8'h28, 8'h00);
      end
      expect_stop("R4 stop", 2'd0);
    end else begin
      stat(ac, 8'h00);
      if (len == 8'd0) begin
        expect_stop("R5 empty read", 2'd0);
      end else begin
        check("R5 cont", {act_valid_o, act_o, ack_o}, {1'b1, 3'd6, len != 8'd1});
        for (int i = 0; i < int'(len) - 1; i++) begin
          b = 8'($urandom);
          stat(8'h50, b);
          check("R5 recv", {act_valid_o, act_o, rx_push_o, rx_data_o, ack_o},
                {1'b1, 3'd5, 1'b1, b, (int'(len) - i - 1) != 1});
        end
        b = 8'($urandom);
        stat(8'h58, b);
        expect_stop("R5 last", 2'd0);
        check("R5 last push", {rx_push_o, rx_data_o}, {1'b1, b});
      end
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R13 watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset", {busy_o, act_valid_o, done_o, core_rst_o, tx_pop_o, rx_push_o, ien_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 stray status while idle
    stat(8'h08, 8'h00);
    check("R8 stray", {act_valid_o, act_o, done_o, tx_pop_o, rx_push_o, busy_o},
          {1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0});

    // directed 7-bit and 10-bit
    run_msg(10'h055, 1'b0, 1'b0, 8'd2);
    run_msg(10'h2A7, 1'b1, 1'b1, 8'd3);
    run_msg(10'h3C1, 1'b1, 1'b0, 8'd0);
    run_msg(10'h012, 1'b0, 1'b1, 8'd1);

    // random mix
    for (int k = 0; k < 30; k++)
      run_msg(10'($urandom), 1'($urandom), 1'($urandom), 8'($urandom % 5));

    // R2 start ignored while busy, R3 repeated start code
    go(10'h033, 1'b0, 1'b0, 1'b0, 8'd1);
    go(10'h1FF, 1'b1, 1'b1, 1'b0, 8'd4);
    check("R2 busy start", act_valid_o, 0);
    stat(8'h10, 8'h00);
    check("R3 repeat start", {act_valid_o, act_o, wdata_o}, {1'b1, 3'd2, exp_a1(10'h033, 1'b0, 1'b0)});
    stat(8'h18, 8'h00);
    expect_data("R2 keeps length");
    stat(8'h28, 8'h00);
    expect_stop("R2 keeps length", 2'd0);

    // R6 no device
    go(10'h044, 1'b0, 1'b0, 1'b0, 8'd2);
    stat(8'h08, 8'h00);
    stat(8'h20, 8'h00);
    expect_stop("R6 addr nack", 2'd1);
    go(10'h044, 1'b0, 1'b1, 1'b0, 8'd2);
    stat(8'h08, 8'h00);
    stat(8'h48, 8'h00);
    expect_stop("R6 read nack", 2'd1);

    // R7 unexpected status
    go(10'h011, 1'b0, 1'b0, 1'b0, 8'd1);
    stat(8'h99, 8'h00);
    expect_stop("R7 bad code", 2'd2);
    check("R7 core reset", core_rst_o, 1);

    // R10 skip start
    go(10'h000, 1'b0, 1'b0, 1'b1, 8'd2);
    expect_data("R10 write first");
    stat(8'h28, 8'h00);
    expect_data("R10 write second");
    stat(8'h28, 8'h00);
    expect_stop("R10 write end", 2'd0);
    go(10'h000, 1'b0, 1'b1, 1'b1, 8'd1);
    check("R10 read", {act_valid_o, act_o, ack_o}, {1'b1, 3'd6, 1'b0});
    stat(8'h58, 8'hA5);
    expect_stop("R10 read end", 2'd0);

    // R11 abort on write
    go(10'h021, 1'b0, 1'b0, 1'b0, 8'd3);
    stat(8'h08, 8'h00);
    pulse_abort();
    stat(8'h18, 8'h00);
    expect_data("R11 abort before first byte");
    stat(8'h28, 8'h00);
    expect_stop("R11 abort write", 2'd0);

    // R11 abort on read
    go(10'h022, 1'b0, 1'b1, 1'b0, 8'd3);
    stat(8'h08, 8'h00);
    stat(8'h40, 8'h00);
    check("R11 ack before abort", ack_o, 1);
    pulse_abort();
    stat(8'h50, 8'h3C);
    check("R11 abort read ack", {act_o, ack_o}, {3'd5, 1'b0});
    stat(8'h58, 8'h3D);
    expect_stop("R11 abort read end", 2'd0);

    // R12 full watchdog
    tmo_i = 16'd10;
    go(10'h050, 1'b0, 1'b0, 1'b0, 8'd1);
    n = 0;
    while (!done_o && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R12 window", n, 22);
    check("R12 timeout", {core_rst_o, result_o, busy_o, act_valid_o}, {1'b1, 2'd3, 1'b0, 1'b0});

    // R12 first window then normal stop
    tmo_i = 16'd20;
    go(10'h051, 1'b0, 1'b0, 1'b0, 8'd3);
    stat(8'h08, 8'h00);
    stat(8'h18, 8'h00);
    expect_data("R12 first byte");
    repeat (25) @(negedge clk);
    check("R12 still busy", busy_o, 1);
    stat(8'h28, 8'h00);
    expect_stop("R12 late stop", 2'd3);

    // R13 stray status after a message
    stat(8'hE8, 8'h00);
    check("R13 idle answer", {act_valid_o, act_o, core_rst_o, done_o}, {1'b1, 3'd7, 1'b0, 1'b0});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule